// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetch Engine

This block sits between system memory and a MAC transmitter. Software places a ring of two-word descriptors in memory. Each descriptor holds a buffer address and a control word with the byte count and per-buffer flags. Once transmit is enabled and a start strobe arrives, the engine walks the ring from its current slot. For each descriptor it reads the control word and tests the ownership flag. It then reads the buffer address, fetches the buffer one 32-bit word at a time, and presents the bytes as a valid/ready stream with a frame-end marker.

When a buffer has been sent, the engine writes the control word back with the ownership flag set and its error status fields cleared. Ownership is inverted: a set flag means software owns the slot. A slot found owned by software at a frame boundary stops the engine quietly. The same condition in the middle of a frame aborts the frame and flags the offending slot. A halt request lets the frame in progress complete before the engine goes idle. Clearing transmit enable returns the ring pointer to the base.

Top module: `txring_dma`

## Requirements
- R1: After reset, `tx_busy`, `mem_req` and `tx_valid` are all low.
- R2: A `tx_start` pulse while idle with `tx_en` high makes the engine read the control word at `ring_base + 8*slot + 4`. If bit 31 (used) of that word is set and no frame is open, the engine returns to idle. It makes no write and emits no byte.
- R3: For a free descriptor, the engine reads the buffer address at `ring_base + 8*slot`. It then emits exactly control[10:0] bytes, starting at that byte address and in ascending address order. Byte k of a word is bits 8k+7:8k (little-endian). `tx_data` holds steady while `tx_valid` is high and `tx_ready` is low.
- R4: `tx_last` is high only on the final byte of a buffer whose control bit 15 is set.
- R5: `tx_nocrc` equals control bit 16 of the current buffer on every emitted byte.
- R6: After the last byte of a buffer, the control word is written back with bit 31 set and bits 29:27 cleared. All other bits are kept as read.
- R7: After a descriptor with control bit 30 set, the next descriptor fetched is slot 0 at `ring_base`. Otherwise the next slot follows.
- R8: If a used descriptor is met after a buffer without bit 15, the engine writes that descriptor's control word back with bit 27 set, emits nothing more, and goes idle.
- R9: A `tx_halt` pulse while busy keeps `tx_busy` high until the write-back of the frame's last buffer. The engine then goes idle, and the next start resumes at the following slot.
- R10: While `tx_en` is low the engine is idle and the slot pointer returns to slot 0.
- R11: `tx_start` has no effect while `tx_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | AW | Byte address of descriptor slot 0 |
| tx_en | input | 1 | Transmit enable; low clears the slot pointer |
| tx_start | input | 1 | Start strobe |
| tx_halt | input | 1 | Request to stop after the current frame |
| tx_busy | output | 1 | Engine is processing the ring |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle; read data is valid |
| mem_rdata | input | 32 | Read data |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_last | output | 1 | Final byte of a frame |
| tx_nocrc | output | 1 | Frame must be sent without appended CRC |
| tx_ready | input | 1 | Transmitter accepts the byte |

## Verification
A slot pointer that has drifted shows up on the first fetch after the next start. The wrong control-word address produces a write-back to the wrong slot, or bytes from the wrong buffer reach the scoreboard within a few memory accesses. A byte counter or byte-lane selector that is off shows up at once as a wrong byte, a missing or early `tx_last`, or a stream that overruns the queue of expected bytes. A stale open-frame or halt flag shows up only at the next frame boundary. It appears there as a missing exhausted flag in memory, or as the engine running on past a halt or stopping before one was asked for.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int DW      = 32;
  localparam int LEN_W   = 11;
  localparam int B_LAST  = 15;
  localparam int B_NOCRC = 16;
  localparam int B_EXH   = 27;
  localparam int B_UND   = 28;
  localparam int B_RTY   = 29;
  localparam int B_WRAP  = 30;
  localparam int B_USED  = 31;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_CTRL, S_RD_ADDR, S_RD_DATA, S_SEND, S_WB, S_ABORT
  } txr_state_e;
endpackage

// File: rtl/txr_ptr.sv
module txr_ptr #(
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic          wrap,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (clr)       idx_d = '0;
    else if (adv)  idx_d = wrap ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign idx = idx_q;

  p_wrap_to_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && wrap && !clr) |=> (idx == '0));
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (idx == '0));
endmodule

// File: rtl/txr_bytesel.sv
module txr_bytesel #(
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int SB = $clog2(NB)
) (
  input  logic [DW-1:0] word,
  input  logic [SB-1:0] sel,
  output logic [7:0]    byte_o
);
  logic [7:0] lane [NB];

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane[g] = word[8*g +: 8];
  end

  assign byte_o = lane[sel];
endmodule

// File: rtl/txring_dma.sv
module txring_dma
  import txr_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base,
  input  logic          tx_en,
  input  logic          tx_start,
  input  logic          tx_halt,
  output logic          tx_busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  output logic          tx_last,
  output logic          tx_nocrc,
  input  logic          tx_ready
);
  localparam int NB     = DW / 8;
  localparam int SB     = $clog2(NB);
  localparam int STRIDE = 2 * NB;
  localparam logic [DW-1:0] STAT_MASK = (DW'(1) << B_EXH) | (DW'(1) << B_UND) | (DW'(1) << B_RTY);

  txr_state_e     state_q, state_d;
  logic [DW-1:0]  ctrl_q, ctrl_d;
  logic [AW-1:0]  ptr_q, ptr_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [DW-1:0]  word_q, word_d;
  logic           mid_q, mid_d;
  logic           halt_q, halt_d;
  logic [IW-1:0]  idx;
  logic [AW-1:0]  desc_addr;
  logic           ptr_adv;

  assign desc_addr = ring_base + (AW'(idx) * AW'(STRIDE));
  assign ptr_adv   = tx_en && (state_q == S_WB) && mem_ack;

  txr_ptr #(.IW(IW)) u_ptr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (!tx_en),
    .adv  (ptr_adv),
    .wrap (ctrl_q[B_WRAP]),
    .idx  (idx)
  );

  txr_bytesel #(.DW(DW)) u_sel (
    .word  (word_q),
    .sel   (ptr_q[SB-1:0]),
    .byte_o(tx_data)
  );

  always_comb begin
    state_d   = state_q;
    ctrl_d    = ctrl_q;
    ptr_d     = ptr_q;
    rem_d     = rem_q;
    word_d    = word_q;
    mid_d     = mid_q;
    halt_d    = halt_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr + AW'(NB);
    mem_wdata = (ctrl_q | (DW'(1) << B_USED)) & ~STAT_MASK;
    if (tx_halt && state_q != S_IDLE) halt_d = 1'b1;
    case (state_q)
      S_IDLE: begin
        if (tx_start) begin
          state_d = S_RD_CTRL;
          halt_d  = 1'b0;
        end
      end
      S_RD_CTRL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          ctrl_d = mem_rdata;
          if (mem_rdata[B_USED])               state_d = mid_q ? S_ABORT : S_IDLE;
          else if (mem_rdata[LEN_W-1:0] == '0) state_d = S_WB;
          else                                 state_d = S_RD_ADDR;
        end
      end
      S_RD_ADDR: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr;
        if (mem_ack) begin
          ptr_d   = mem_rdata[AW-1:0];
          rem_d   = ctrl_q[LEN_W-1:0];
          state_d = S_RD_DATA;
        end
      end
      S_RD_DATA: begin
        mem_req  = 1'b1;
        mem_addr = {ptr_q[AW-1:SB], {SB{1'b0}}};
        if (mem_ack) begin
          word_d  = mem_rdata;
          state_d = S_SEND;
        end
      end
      S_SEND: begin
        if (tx_ready) begin
          rem_d = rem_q - 1'b1;
          ptr_d = ptr_q + 1'b1;
          if (rem_q == LEN_W'(1))          state_d = S_WB;
          else if (&ptr_q[SB-1:0])          state_d = S_RD_DATA;
        end
      end
      S_WB: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          mid_d   = !ctrl_q[B_LAST];
          state_d = (ctrl_q[B_LAST] && halt_q) ? S_IDLE : S_RD_CTRL;
        end
      end
      S_ABORT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = ctrl_q | (DW'(1) << B_EXH);
        if (mem_ack) begin
          mid_d   = 1'b0;
          state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (!tx_en) begin
      state_d = S_IDLE;
      mid_d   = 1'b0;
      halt_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ctrl_q  <= '0;
      ptr_q   <= '0;
      rem_q   <= '0;
      word_q  <= '0;
      mid_q   <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ctrl_q  <= ctrl_d;
      ptr_q   <= ptr_d;
      rem_q   <= rem_d;
      word_q  <= word_d;
      mid_q   <= mid_d;
      halt_q  <= halt_d;
    end
  end

  assign tx_busy  = (state_q != S_IDLE);
  assign tx_valid = (state_q == S_SEND);
  assign tx_last  = tx_valid && (rem_q == LEN_W'(1)) && ctrl_q[B_LAST];
  assign tx_nocrc = tx_valid && ctrl_q[B_NOCRC];

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> (!tx_valid && !mem_req));
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && tx_en) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && tx_en) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
  p_wb_owned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[B_USED]);
  p_abort_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack && mem_wdata[B_EXH]) |=> !tx_busy);
  p_disable_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !tx_busy);
endmodule

// File: tb/sim_txring_dma.sv
module sim_txring_dma;
  localparam int RB = 32'h100;
  localparam logic [31:0] USED = 32'h8000_0000;
  localparam logic [31:0] WRAP = 32'h4000_0000;
  localparam logic [31:0] EXH  = 32'h0800_0000;
  localparam logic [31:0] UND  = 32'h1000_0000;
  localparam logic [31:0] NOCRC = 32'h0001_0000;
  localparam logic [31:0] LAST = 32'h0000_8000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] ring_base = RB;
  logic tx_en = 1'b0, tx_start = 1'b0, tx_halt = 1'b0;
  logic tx_busy, mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0] tx_data;
  logic tx_valid, tx_last, tx_nocrc;
  logic tx_ready = 1'b0;

  logic [31:0] mem [512];
  logic [1:0]  wait_q;
  logic [4:0]  lfsr;
  logic [9:0]  exp_q [$];
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  txring_dma u0 (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .tx_en(tx_en),
    .tx_start(tx_start), .tx_halt(tx_halt), .tx_busy(tx_busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last),
    .tx_nocrc(tx_nocrc), .tx_ready(tx_ready)
  );

  assign mem_ack   = mem_req && (wait_q == 2'd1);
  assign mem_rdata = mem[mem_addr[10:2]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
      lfsr   <= 5'h1;
    end else begin
      wait_q   <= (mem_req && !mem_ack) ? wait_q + 1'b1 : 2'd0;
      lfsr     <= {lfsr[3:0], lfsr[4] ^ lfsr[2]};
      tx_ready <= lfsr[0] | lfsr[3];
      if (mem_req && mem_we && mem_ack) mem[mem_addr[10:2]] <= mem_wdata;
    end
  end

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 7 + 3);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_desc(input int i, input logic [31:0] addr, input logic [31:0] ctrl);
    mem[(RB + 8*i) >> 2]     = addr;
    mem[(RB + 8*i + 4) >> 2] = ctrl;
  endtask

  function automatic logic [31:0] ctrl_of(input int i);
    return mem[(RB + 8*i + 4) >> 2];
  endfunction

  task automatic push_buf(input int addr, input int len, input bit last, input bit nocrc);
    for (int k = 0; k < len; k++)
      exp_q.push_back({last && (k == len-1), nocrc, pat(addr + k)});
  endtask

  task automatic pulse_start();
    @(negedge clk) tx_start = 1'b1;
    @(negedge clk) tx_start = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (!tx_busy) return;
    end
    chk(1'b0, req, 32'd1, 32'd0);
  endtask

  // Scoreboard monitor: compares every accepted byte (R3 R4 R5)
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected byte", {22'd0, tx_last, tx_nocrc, tx_data}, 32'd0);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk({tx_last, tx_nocrc, tx_data} == e, "R3 R4 R5 stream byte",
            {22'd0, tx_last, tx_nocrc, tx_data}, {22'd0, e});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < 512; a++)
      mem[a] = {pat(4*a+3), pat(4*a+2), pat(4*a+1), pat(4*a)};
    set_desc(0, 32'h400, 32'd5 | UND);
    set_desc(1, 32'h481, 32'd3 | LAST | NOCRC);
    set_desc(2, 32'h4C0, USED | 32'd7);
    set_desc(3, 32'h4E0, USED | WRAP);

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!tx_busy, "R1 busy", 32'(tx_busy), 32'd0);
    chk(!mem_req, "R1 mem_req", 32'(mem_req), 32'd0);
    chk(!tx_valid, "R1 tx_valid", 32'(tx_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk) tx_en = 1'b1;

    // T2: two-buffer frame, then used slot at frame start (R2 R3 R6)
    push_buf(32'h400, 5, 1'b0, 1'b0);
    push_buf(32'h481, 3, 1'b1, 1'b1);
    pulse_start();
    wait_idle("R2 idle timeout");
    chk(exp_q.size() == 0, "R3 bytes left", 32'(exp_q.size()), 32'd0);
    chk(ctrl_of(0) == (32'd5 | USED), "R6 wb slot0", ctrl_of(0), 32'd5 | USED);
    chk(ctrl_of(1) == (32'd3 | LAST | NOCRC | USED), "R6 wb slot1", ctrl_of(1), 32'd3 | LAST | NOCRC | USED);
    chk(ctrl_of(2) == (USED | 32'd7), "R2 used slot untouched", ctrl_of(2), USED | 32'd7);

    // T3: wrap from slot 3 to slot 0 (R7)
    set_desc(2, 32'h500, 32'd2 | LAST);
    set_desc(3, 32'h520, 32'd1 | LAST | WRAP);
    set_desc(0, 32'h540, 32'd2 | LAST);
    push_buf(32'h500, 2, 1'b1, 1'b0);
    push_buf(32'h520, 1, 1'b1, 1'b0);
    push_buf(32'h540, 2, 1'b1, 1'b0);
    pulse_start();
    wait_idle("R7 idle timeout");
    chk(exp_q.size() == 0, "R7 bytes left", 32'(exp_q.size()), 32'd0);
    chk(ctrl_of(3) == (32'd1 | LAST | WRAP | USED), "R7 wb slot3", ctrl_of(3), 32'd1 | LAST | WRAP | USED);
    chk(ctrl_of(0) == (32'd2 | LAST | USED), "R7 wb slot0 after wrap", ctrl_of(0), 32'd2 | LAST | USED);

    // T4: used slot in mid-frame (R8); pointer at slot 1
    set_desc(1, 32'h560, 32'd3);
    push_buf(32'h560, 3, 1'b0, 1'b0);
    pulse_start();
    wait_idle("R8 idle timeout");
    chk(exp_q.size() == 0, "R8 bytes left", 32'(exp_q.size()), 32'd0);
    chk(ctrl_of(1) == (32'd3 | USED), "R8 wb slot1", ctrl_of(1), 32'd3 | USED);
    chk(ctrl_of(2) == (32'd2 | LAST | USED | EXH), "R8 exhausted flag", ctrl_of(2), 32'd2 | LAST | USED | EXH);

    // T5: halt during frame (R9); pointer still at slot 2
    set_desc(2, 32'h580, 32'd4 | LAST);
    set_desc(3, 32'h5A0, 32'd2 | LAST | WRAP);
    push_buf(32'h580, 4, 1'b1, 1'b0);
    pulse_start();
    do @(negedge clk); while (!(tx_valid && tx_ready));
    tx_halt = 1'b1;
    @(negedge clk) tx_halt = 1'b0;
    chk(tx_busy, "R9 busy held after halt", 32'(tx_busy), 32'd1);
    wait_idle("R9 idle timeout");
    chk(exp_q.size() == 0, "R9 frame completed", 32'(exp_q.size()), 32'd0);
    chk(ctrl_of(2) == (32'd4 | LAST | USED), "R9 wb slot2", ctrl_of(2), 32'd4 | LAST | USED);
    chk(ctrl_of(3) == (32'd2 | LAST | WRAP), "R9 next slot untouched", ctrl_of(3), 32'd2 | LAST | WRAP);
    push_buf(32'h5A0, 2, 1'b1, 1'b0);
    pulse_start();
    wait_idle("R9 resume timeout");
    chk(exp_q.size() == 0, "R9 resumed at next slot", 32'(exp_q.size()), 32'd0);
    chk(ctrl_of(3) == (32'd2 | LAST | WRAP | USED), "R9 wb slot3", ctrl_of(3), 32'd2 | LAST | WRAP | USED);

    // T6: move pointer to slot 1, then enable drop (R10) and start while disabled (R11)
    set_desc(0, 32'h5C0, 32'd1 | LAST);
    push_buf(32'h5C0, 1, 1'b1, 1'b0);
    pulse_start();
    wait_idle("R10 setup timeout");
    chk(exp_q.size() == 0, "R10 setup bytes", 32'(exp_q.size()), 32'd0);
    @(negedge clk) tx_en = 1'b0;
    pulse_start();
    repeat (4) @(negedge clk);
    chk(!tx_busy, "R11 start ignored busy", 32'(tx_busy), 32'd0);
    chk(!mem_req, "R11 start ignored mem_req", 32'(mem_req), 32'd0);
    tx_en = 1'b1;
    set_desc(0, 32'h5E0, 32'd2 | LAST);
    push_buf(32'h5E0, 2, 1'b1, 1'b0);
    pulse_start();
    wait_idle("R10 idle timeout");
    chk(exp_q.size() == 0, "R10 restart from base", 32'(exp_q.size()), 32'd0);
    chk(ctrl_of(0) == (32'd2 | LAST | USED), "R10 wb slot0", ctrl_of(0), 32'd2 | LAST | USED);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule